// File: doc/BRIEF.md
# VCO and Divider Search Engine

This block looks for the oscillator setting that best serves two derived clocks. When a start pulse comes in, it takes two requested output frequencies and a reference frequency, all in kHz. It then steps through candidate oscillator frequencies, one per clock cycle.

For each candidate it works out three values:
- a fixed-point feedback divider;
- a post-divider for each requested clock, from two rule evaluators that work side by side.

It scores the candidate by the total shortfall of the two achieved clocks against the requests, and it keeps the best candidate seen so far. The sweep can end early for several reasons: the divider leaves its range, a post-divider cannot be formed, or a perfect match is found.

When the search ends, `done` rises and stays high. The chosen feedback divider, both post-dividers and the chosen oscillator frequency are then held on the outputs until the next accepted start. A controller that programs the oscillator reads them from there.

Top module: `vco_div_search`

## Requirements
- R1: While reset is active and after it is released, `busy` and `done` are 0 and `fb_div`, `pdiv_a`, `pdiv_b` and `vco_sel` are 0.
- R2: A `start` pulse seen while `busy` is 0 captures `req_a`, `req_b` and `ref_khz`. It clears `done` and all result outputs, and raises `busy` in the next cycle. A `start` seen while `busy` is 1 is ignored: the running search keeps its captured inputs and produces its own result.
- R3: Candidates run upward from 125000 to 250000 kHz in steps of 100, one candidate per clock cycle. If the search examines N candidates, counting the one at which it stops, `done` first reads 1 N cycles after the cycle in which `start` was captured. `done` then stays 1 and `busy` stays 0 until the next start is captured.
- R4: A candidate's feedback divider is the integer quotient of the candidate over the reference, multiplied by 16384. If this value is above 0x3FFFFFF (67108863), the sweep stops at that candidate and the candidate is not accepted.
- R5: A post-divider for target T at candidate V is formed in three steps:
  1. Start from d = V/T, rounded down.
  2. Add 1 if V/d (rounded down) is still above T.
  3. Then add 1 if d is above 5 and odd.

  The achieved frequency is V/d, rounded down.
- R6: A post-divider is invalid in three cases: the target is 0, the candidate is below the target, or d reaches 128 or more. An invalid post-divider for either clock stops the sweep at that candidate, and the candidate is not accepted.
- R7: A candidate's score is |req_a − achieved_a| + |req_b − achieved_b|. The stored best score starts at 0x7FFFFFF. A candidate replaces the stored result only when its score is strictly lower.
- R8: When an accepted candidate has score 0, the sweep ends at that candidate.
- R9: If no candidate is ever accepted, all result outputs read 0 and `done` is still raised.
- R10: A zero `ref_khz` ends the search after one cycle, with all result outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; ignored while busy |
| req_a | input | FW | First requested clock, kHz |
| req_b | input | FW | Second requested clock, kHz |
| ref_khz | input | FW | Reference frequency, kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, results valid |
| fb_div | output | FB_W | Best feedback divider |
| pdiv_a | output | PD_W | Best post-divider for the first clock |
| pdiv_b | output | PD_W | Best post-divider for the second clock |
| vco_sel | output | FW | Best oscillator frequency, kHz |

## Verification
The two functions that can meet in one cycle are:
- the end of a search;
- the acceptance of a new start.

The bench first works out, from its own model, how many candidates a request will examine. It then raises `start` with different inputs exactly on that final candidate's edge, and again part-way through a search. It judges the outcome at the ports. The results must match the first request, `done` must stay high with `busy` low, and the cycle count must be unchanged.

// File: rtl/vco_div_search.sv
module vco_div_search #(
  parameter int FW       = 18,
  parameter int FB_W     = 26,
  parameter int FB_SHIFT = 14,
  parameter int PD_W     = 7,
  parameter int SW       = 28,
  parameter int VCO_MIN  = 125000,
  parameter int VCO_MAX  = 250000,
  parameter int VCO_STEP = 100,
  parameter int SCORE_INIT = 'h7FFFFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FW-1:0]   req_a,
  input  logic [FW-1:0]   req_b,
  input  logic [FW-1:0]   ref_khz,
  output logic            busy,
  output logic            done,
  output logic [FB_W-1:0] fb_div,
  output logic [PD_W-1:0] pdiv_a,
  output logic [PD_W-1:0] pdiv_b,
  output logic [FW-1:0]   vco_sel
);

  localparam int DW       = FW + 1;
  localparam int FBX_W    = FW + FB_SHIFT;
  localparam int PD_LIMIT = 1 << PD_W;
  localparam logic [FBX_W-1:0] FB_LIMIT = FBX_W'((64'd1 << FB_W) - 64'd1);

  typedef struct packed {
    logic          ok;
    logic [DW-1:0] div;
    logic [FW-1:0] ach;
  } pd_t;

  function automatic pd_t post_div(input logic [FW-1:0] v, input logic [FW-1:0] t);
    pd_t r;
    logic [DW-1:0] d;
    r = '0;
    if (t != '0 && v >= t) begin
      d = DW'(v / t);
      if (DW'(v) / d > DW'(t)) d = d + 1'b1;
      if (d > DW'(5) && d[0]) d = d + 1'b1;
      if (d < DW'(PD_LIMIT)) begin
        r.ok  = 1'b1;
        r.div = d;
        r.ach = FW'(DW'(v) / d);
      end
    end
    return r;
  endfunction

  function automatic logic [FW-1:0] abs_diff(input logic [FW-1:0] x, input logic [FW-1:0] y);
    return (x >= y) ? x - y : y - x;
  endfunction

  logic [FW-1:0] cap_a, cap_b, cap_ref, vco;
  logic [SW-1:0] best_score;

  logic [FW-1:0]    quo;
  logic [FBX_W-1:0] fb_full;
  logic             fb_bad, ref_zero, cand_ok, better, stop;
  pd_t              pa, pb;
  logic [SW-1:0]    score;

  assign ref_zero = (cap_ref == '0);
  assign quo      = ref_zero ? '0 : vco / cap_ref;
  assign fb_full  = FBX_W'(quo) << FB_SHIFT;
  assign fb_bad   = fb_full > FB_LIMIT;
  assign pa       = post_div(vco, cap_a);
  assign pb       = post_div(vco, cap_b);
  assign score    = SW'(abs_diff(cap_a, pa.ach)) + SW'(abs_diff(cap_b, pb.ach));
  assign cand_ok  = !ref_zero && !fb_bad && pa.ok && pb.ok;
  assign better   = cand_ok && (score < best_score);
  assign stop     = !cand_ok || (better && score == '0) || (vco >= FW'(VCO_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      cap_a      <= '0;
      cap_b      <= '0;
      cap_ref    <= '0;
      vco        <= FW'(VCO_MIN);
      best_score <= SW'(SCORE_INIT);
      fb_div     <= '0;
      pdiv_a     <= '0;
      pdiv_b     <= '0;
      vco_sel    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy       <= 1'b1;
        done       <= 1'b0;
        cap_a      <= req_a;
        cap_b      <= req_b;
        cap_ref    <= ref_khz;
        vco        <= FW'(VCO_MIN);
        best_score <= SW'(SCORE_INIT);
        fb_div     <= '0;
        pdiv_a     <= '0;
        pdiv_b     <= '0;
        vco_sel    <= '0;
      end
    end else begin
      if (better) begin
        best_score <= score;
        fb_div     <= fb_full[FB_W-1:0];
        pdiv_a     <= pa.div[PD_W-1:0];
        pdiv_b     <= pb.div[PD_W-1:0];
        vco_sel    <= vco;
      end
      if (stop) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        vco <= vco + FW'(VCO_STEP);
      end
    end
  end

  a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r3_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  a_r3_vco_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vco >= FW'(VCO_MIN)) && (vco <= FW'(VCO_MAX)));

  a_r2_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cap_a) && $stable(cap_b) && $stable(cap_ref));

  a_r2_run_to_end: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);

  a_r7_score_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> best_score <= $past(best_score));

  a_r5_even_pdiv_a: assert property (@(posedge clk) disable iff (!rst_n)
    done && pdiv_a > PD_W'(5) |-> !pdiv_a[0]);

  a_r5_even_pdiv_b: assert property (@(posedge clk) disable iff (!rst_n)
    done && pdiv_b > PD_W'(5) |-> !pdiv_b[0]);

  a_r9_empty_result: assert property (@(posedge clk) disable iff (!rst_n)
    done && vco_sel == '0 |-> fb_div == '0 && pdiv_a == '0 && pdiv_b == '0);

endmodule

// File: tb/vco_div_search_tb.sv
module vco_div_search_tb_top;
  localparam int FW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0] req_a = '0, req_b = '0, ref_khz = '0;
  logic busy, done;
  logic [25:0] fb_div;
  logic [6:0] pdiv_a, pdiv_b;
  logic [FW-1:0] vco_sel;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  vco_div_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_a(req_a), .req_b(req_b),
    .ref_khz(ref_khz), .busy(busy), .done(done), .fb_div(fb_div),
    .pdiv_a(pdiv_a), .pdiv_b(pdiv_b), .vco_sel(vco_sel));

  typedef struct {
    longint fb, pa, pb, vco;
    int     cycles;
  } exp_t;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit pdiv(input longint v, input longint t,
                              output longint d, output longint ach);
    d = 0; ach = 0;
    if (t == 0 || v < t) return 0;
    d = v / t;
    if (v / d > t) d++;
    if (d > 5 && (d % 2) == 1) d++;
    if (d >= 128) return 0;
    ach = v / d;
    return 1;
  endfunction

  function automatic exp_t model(input longint a, input longint b, input longint r);
    exp_t e;
    longint best, da, db, xa, xb, fb, sc, la, lb;
    bit oka, okb;
    e = '{0, 0, 0, 0, 0};
    best = 'h7FFFFFF;
    for (longint v = 125000; v <= 250000; v += 100) begin
      e.cycles++;
      if (r == 0) break;
      fb = (v / r) * 16384;
      if (fb > 'h3FFFFFF) break;
      oka = pdiv(v, a, da, xa);
      okb = pdiv(v, b, db, xb);
      if (!oka || !okb) break;
      la = (a >= xa) ? a - xa : xa - a;
      lb = (b >= xb) ? b - xb : xb - b;
      sc = la + lb;
      if (sc < best) begin
        best = sc; e.fb = fb; e.pa = da; e.pb = db; e.vco = v;
        if (sc == 0) break;
      end
    end
    return e;
  endfunction

  task automatic check_result(input string req, input exp_t e);
    chk(fb_div == e.fb, req, "fb_div", fb_div, e.fb);
    chk(pdiv_a == e.pa, req, "pdiv_a", pdiv_a, e.pa);
    chk(pdiv_b == e.pb, req, "pdiv_b", pdiv_b, e.pb);
    chk(vco_sel == e.vco, req, "vco_sel", vco_sel, e.vco);
  endtask

  // Generic search; interrupt_at > 0 pulses start with other inputs on that cycle count
  task automatic run_search(input string req, input int a, input int b, input int r,
                            input int interrupt_at);
    exp_t e;
    int cnt;
    e = model(a, b, r);
    @(negedge clk);
    req_a = FW'(a); req_b = FW'(b); ref_khz = FW'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2", "busy after start", {busy, done}, 2);
    cnt = 0;
    while (!done && cnt < 3000) begin
      if (interrupt_at > 0 && cnt == interrupt_at - 1) begin
        req_a = FW'(a / 2 + 7); req_b = FW'(b / 3 + 1); ref_khz = FW'(r + 3); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(cnt == e.cycles, "R3", {req, " cycles to done"}, cnt, e.cycles);
    check_result(req, e);
    repeat (2) @(negedge clk);
    chk(done && !busy, "R3", "done held", {done, busy}, 2);
    check_result(req, e);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(fb_div == 0 && pdiv_a == 0 && pdiv_b == 0 && vco_sel == 0,
        "R1", "results after reset", fb_div, 0);
  endtask

  task automatic t_typical();
    run_search("R5 R7 typical", 53300, 40000, 100, 0);
    run_search("R5 R7 odd-rule", 21500, 17900, 27, 0);
  endtask

  task automatic t_zero_score();
    exp_t e;
    e = model(62500, 125000, 100);
    chk(e.cycles == 1, "R8", "model exact at first", e.cycles, 1);
    run_search("R8 exact first", 62500, 125000, 100, 0);
    run_search("R8 exact later", 64000, 32000, 100, 0);
  endtask

  task automatic t_fb_limit();
    run_search("R4 fb overflow mid", 33333, 27000, 50, 0);
    run_search("R4 R9 fb overflow first", 40000, 30000, 1, 0);
  endtask

  task automatic t_invalid_pdiv();
    run_search("R6 R9 target above vco", 130000, 40000, 100, 0);
    run_search("R6 div limit", 1000, 50000, 100, 0);
    run_search("R6 R9 zero target", 0, 50000, 100, 0);
  endtask

  task automatic t_zero_ref();
    run_search("R10 zero reference", 50000, 40000, 0, 0);
    chk(vco_sel == 0 && fb_div == 0, "R10", "zero outputs", vco_sel, 0);
  endtask

  task automatic t_start_collision();
    exp_t e;
    run_search("R2 start mid-run", 53300, 40000, 100, 5);
    e = model(33333, 27000, 50);
    run_search("R2 start on final cycle", 33333, 27000, 50, e.cycles);
  endtask

  initial begin
    t_reset();
    t_typical();
    t_zero_score();
    t_fb_limit();
    t_invalid_pdiv();
    t_zero_ref();
    t_start_collision();
    summary();
  end
endmodule